// File: doc/BRIEF.md
# Four-Channel Host Mailbox Port

This block sits between an external host bus and local firmware and gives them four independent mailboxes. Each mailbox has an inbound register that the host writes, an outbound register that the host reads, and a status byte that both sides can see. On the host side each mailbox has its own active-low select line. The host bus also has active-low read and write strobes and one address bit. On a write, that address bit marks the byte as a command or as plain data. On a read, it chooses between the outbound data register and the status byte.

The host strobes are asynchronous to the local clock. They pass through a synchronizer, and a transfer takes effect when its strobe is released, so each strobe counts as exactly one event however long it is held. The local side is a plain register port: it selects a channel, writes the outbound register, and reads and acknowledges the inbound register. Each channel has a level interrupt that stays high while its inbound register holds unread host data.

Top module: `hostmbx_top`

## Requirements
- R1: After reset, every inbound and outbound register reads 0, every status byte reads 0, and all interrupt outputs are low.
- R2: The status byte carries the outbound-full flag in bit 0, the inbound-full flag in bit 1 and the command tag in bit 3; all other bits are 0. While a select line is low and `ha0` is 0, `hdout` shows that channel's outbound register; while `ha0` is 1, it shows that channel's status byte.
- R3: A host write with `ha0`=0 stores `hdin` in the channel's inbound register and clears the command tag. With `ha0`=1 it stores `hdin` and sets the command tag.
- R4: A host write sets the channel's inbound-full flag and drives its `irq` bit high. A local read of that channel (`lcl_rd` with `lcl_ch`) clears the flag and the `irq` bit.
- R5: A local write sets the outbound-full flag and loads `lcl_wdata`. A host read with `ha0`=0 clears that flag when its strobe is released. A host status read (`ha0`=1) leaves the flag unchanged.
- R6: If the read and write strobes are both low at any time during one access, that access changes no register and no flag. This holds whether the strobes are released together or one after the other.
- R7: A write strobe held low for many cycles sets nothing while it is held. On release it causes exactly one update, and that update does not come back after a local read clears it.
- R8: Only the lowest-numbered channel whose select line is low takes part in an access. An access with no select line low changes nothing. Other channels keep their contents.
- R9: If a host write event and a local read of the same channel fall in the same cycle, the inbound-full flag stays set and the new byte is kept. If a host data read event and a local write fall in the same cycle, the outbound-full flag stays set and the new byte is kept.
- R10: With the default two synchronizer stages, a host write first shows on `irq` after the third rising clock edge that follows the release of the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcs_n | input | NCH | Active-low host select, one per channel |
| hrd_n | input | 1 | Active-low host read strobe |
| hwr_n | input | 1 | Active-low host write strobe |
| ha0 | input | 1 | Host address bit: command/status when 1, data when 0 |
| hdin | input | DW | Host write data |
| hdout | output | DW | Host read data (outbound register or status byte) |
| lcl_ch | input | CHW | Channel picked by the local port |
| lcl_wr | input | 1 | Local write of the outbound register |
| lcl_rd | input | 1 | Local read and acknowledge of the inbound register |
| lcl_wdata | input | DW | Local write data |
| lcl_rdata | output | DW | Inbound register of the picked channel |
| lcl_status | output | DW | Status byte of the picked channel |
| irq | output | NCH | Per-channel inbound-full interrupt |

## Verification
Two pairs of events can land in the same clock cycle. A host write event can meet a local acknowledge of the same channel, and a host data read event can meet a local write of the same outbound register. The bench provokes each collision on purpose. It releases the host strobe, counts the synchronizer stages, and pulses the local strobe so that it is sampled on exactly the edge where the host event registers. It then judges the outcome by two things: the flag must still be set and the register must hold the new byte, and in the read case the local side must still see the old inbound byte during that cycle.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CMD = 3;
    localparam int ST_MIN_W = 4;
endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
    parameter int W = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hmb_host_decode.sv
module hmb_host_decode #(
    parameter int NCH = 4,
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] s_cs_n,
    input  logic           s_a0,
    input  logic [DW-1:0]  s_din,
    input  logic           s_wr_n,
    input  logic           s_rd_n,
    output logic [NCH-1:0] wr_ev_o,
    output logic [NCH-1:0] rd_odr_ev_o,
    output logic           ev_a0_o,
    output logic [DW-1:0]  ev_din_o
);
    typedef struct packed {
        logic [NCH-1:0] cs_n;
        logic           a0;
        logic [DW-1:0]  din;
        logic           wr_n;
        logic           rd_n;
        logic           bad;
    } dec_t;

    dec_t           st_d, st_q;
    logic [NCH-1:0] sel;
    logic           found;
    logic           wr_rise;
    logic           rd_rise;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (!found && !st_q.cs_n[i]) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end

        wr_rise = !st_q.wr_n && s_wr_n && st_q.rd_n && !st_q.bad;
        rd_rise = !st_q.rd_n && s_rd_n && st_q.wr_n && !st_q.bad;

        wr_ev_o     = wr_rise ? sel : '0;
        rd_odr_ev_o = (rd_rise && !st_q.a0) ? sel : '0;
        ev_a0_o     = st_q.a0;
        ev_din_o    = st_q.din;

        st_d.cs_n = s_cs_n;
        st_d.a0   = s_a0;
        st_d.din  = s_din;
        st_d.wr_n = s_wr_n;
        st_d.rd_n = s_rd_n;
        if (!s_wr_n && !s_rd_n) begin
            st_d.bad = 1'b1;
        end else if (s_wr_n && s_rd_n) begin
            st_d.bad = 1'b0;
        end else begin
            st_d.bad = st_q.bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_n <= '1;
            st_q.a0   <= 1'b0;
            st_q.din  <= '0;
            st_q.wr_n <= 1'b1;
            st_q.rd_n <= 1'b1;
            st_q.bad  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    both_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_wr_n && !s_rd_n) |=> (wr_ev_o == '0 && rd_odr_ev_o == '0));

    // R6
    no_rw_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((|wr_ev_o) && (|rd_odr_ev_o)));

    // R7
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_ev_o) |=> (wr_ev_o == '0));
endmodule

// File: rtl/hmb_chan.sv
module hmb_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_a0,
    input  logic [DW-1:0] host_din,
    input  logic          host_rd_odr,
    input  logic          lcl_wr,
    input  logic [DW-1:0] lcl_wdata,
    input  logic          lcl_rd,
    output logic [DW-1:0] idr_o,
    output logic [DW-1:0] odr_o,
    output logic [DW-1:0] status_o
);
    import hmb_pkg::*;

    typedef struct packed {
        logic [DW-1:0] idr;
        logic [DW-1:0] odr;
        logic          ibf;
        logic          obf;
        logic          cmd;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (lcl_wr) begin
            ch_d.odr = lcl_wdata;
            ch_d.obf = 1'b1;
        end else if (host_rd_odr) begin
            ch_d.obf = 1'b0;
        end
        if (host_wr) begin
            ch_d.idr = host_din;
            ch_d.cmd = host_a0;
            ch_d.ibf = 1'b1;
        end else if (lcl_rd) begin
            ch_d.ibf = 1'b0;
        end

        status_o         = '0;
        status_o[ST_OBF] = ch_q.obf;
        status_o[ST_IBF] = ch_q.ibf;
        status_o[ST_CMD] = ch_q.cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign idr_o = ch_q.idr;
    assign odr_o = ch_q.odr;

    // R4
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ch_q.ibf);

    // R4
    ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_rd && !host_wr) |=> !ch_q.ibf);

    // R3
    cmd_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (ch_q.cmd == $past(host_a0)));

    // R5
    obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_odr && !lcl_wr) |=> !ch_q.obf);

    // R9
    ibf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && lcl_rd) |=> (ch_q.ibf && ch_q.idr == $past(host_din)));

    // R9
    obf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_wr && host_rd_odr) |=> (ch_q.obf && ch_q.odr == $past(lcl_wdata)));
endmodule

// File: rtl/hostmbx_top.sv
module hostmbx_top #(
    parameter int NCH = 4,
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hcs_n,
    input  logic           hrd_n,
    input  logic           hwr_n,
    input  logic           ha0,
    input  logic [DW-1:0]  hdin,
    output logic [DW-1:0]  hdout,
    input  logic [CHW-1:0] lcl_ch,
    input  logic           lcl_wr,
    input  logic           lcl_rd,
    input  logic [DW-1:0]  lcl_wdata,
    output logic [DW-1:0]  lcl_rdata,
    output logic [DW-1:0]  lcl_status,
    output logic [NCH-1:0] irq
);
    import hmb_pkg::*;

    localparam int SW = NCH + DW + 3;

    logic [SW-1:0]  raw_bus;
    logic [SW-1:0]  syn_bus;
    logic [NCH-1:0] s_cs_n;
    logic           s_a0;
    logic [DW-1:0]  s_din;
    logic           s_wr_n;
    logic           s_rd_n;
    logic [NCH-1:0] wr_ev;
    logic [NCH-1:0] rd_odr_ev;
    logic           ev_a0;
    logic [DW-1:0]  ev_din;
    logic [DW-1:0]  idr_w  [NCH];
    logic [DW-1:0]  odr_w  [NCH];
    logic [DW-1:0]  stat_w [NCH];
    logic           hfound;

    assign raw_bus = {hcs_n, ha0, hdin, hwr_n, hrd_n};

    hmb_sync #(
        .W      (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL({{NCH{1'b1}}, 1'b0, {DW{1'b0}}, 2'b11})
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_bus),
        .q_o  (syn_bus)
    );

    assign {s_cs_n, s_a0, s_din, s_wr_n, s_rd_n} = syn_bus;

    hmb_host_decode #(
        .NCH(NCH),
        .DW (DW)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_cs_n     (s_cs_n),
        .s_a0       (s_a0),
        .s_din      (s_din),
        .s_wr_n     (s_wr_n),
        .s_rd_n     (s_rd_n),
        .wr_ev_o    (wr_ev),
        .rd_odr_ev_o(rd_odr_ev),
        .ev_a0_o    (ev_a0),
        .ev_din_o   (ev_din)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        hmb_chan #(
            .DW(DW)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .host_wr    (wr_ev[g]),
            .host_a0    (ev_a0),
            .host_din   (ev_din),
            .host_rd_odr(rd_odr_ev[g]),
            .lcl_wr     (lcl_wr && (int'(lcl_ch) == g)),
            .lcl_wdata  (lcl_wdata),
            .lcl_rd     (lcl_rd && (int'(lcl_ch) == g)),
            .idr_o      (idr_w[g]),
            .odr_o      (odr_w[g]),
            .status_o   (stat_w[g])
        );
        assign irq[g] = stat_w[g][ST_IBF];
    end

    always_comb begin
        hdout  = '0;
        hfound = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (!hfound && !hcs_n[i]) begin
                hfound = 1'b1;
                hdout  = ha0 ? stat_w[i] : odr_w[i];
            end
        end
        lcl_rdata  = '0;
        lcl_status = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(lcl_ch) == i) begin
                lcl_rdata  = idr_w[i];
                lcl_status = stat_w[i];
            end
        end
    end
endmodule

// File: tb/hostmbx_top_test.sv
module hostmbx_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] hcs_n = '1;
    logic           hrd_n = 1'b1;
    logic           hwr_n = 1'b1;
    logic           ha0 = 1'b0;
    logic [DW-1:0]  hdin = '0;
    logic [DW-1:0]  hdout;
    logic [1:0]     lcl_ch = '0;
    logic           lcl_wr = 1'b0;
    logic           lcl_rd = 1'b0;
    logic [DW-1:0]  lcl_wdata = '0;
    logic [DW-1:0]  lcl_rdata;
    logic [DW-1:0]  lcl_status;
    logic [NCH-1:0] irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostmbx_top #(.NCH(NCH), .DW(DW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
        .ha0(ha0), .hdin(hdin), .hdout(hdout), .lcl_ch(lcl_ch), .lcl_wr(lcl_wr),
        .lcl_rd(lcl_rd), .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
        .lcl_status(lcl_status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [NCH-1:0] cs, input logic a, input logic [DW-1:0] d);
        @(negedge clk);
        hcs_n = cs; ha0 = a; hdin = d; hwr_n = 1'b0;
        idle(4);
        hwr_n = 1'b1;
        idle(6);
        hcs_n = '1;
        idle(1);
    endtask

    task automatic host_rd(input int ch, input logic a, output logic [DW-1:0] v);
        @(negedge clk);
        hcs_n = '1; hcs_n[ch] = 1'b0; ha0 = a; hrd_n = 1'b0;
        idle(2);
        v = hdout;
        hrd_n = 1'b1;
        idle(6);
        hcs_n = '1;
        idle(1);
    endtask

    task automatic lcl_write(input int ch, input logic [DW-1:0] d);
        @(negedge clk);
        lcl_ch = 2'(ch); lcl_wdata = d; lcl_wr = 1'b1;
        @(negedge clk);
        lcl_wr = 1'b0;
    endtask

    task automatic lcl_read(input int ch, output logic [DW-1:0] v);
        @(negedge clk);
        lcl_ch = 2'(ch); lcl_rd = 1'b1;
        #1 v = lcl_rdata;
        @(negedge clk);
        lcl_rd = 1'b0;
    endtask

    task automatic look(input int ch);
        @(negedge clk);
        lcl_ch = 2'(ch);
        #1;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check("R1 irq", irq, 0);
        for (int c = 0; c < NCH; c++) begin
            look(c);
            check("R1 status", lcl_status, 0);
            check("R1 inbound", lcl_rdata, 0);
            host_rd(c, 1'b1, v);
            check("R1 host status", v, 0);
            host_rd(c, 1'b0, v);
            check("R1 outbound", v, 0);
        end
    endtask

    task automatic t_write_data();
        logic [DW-1:0] v;
        host_wr(4'b1110, 1'b0, 8'h5A);
        look(0);
        check("R3 data stored", lcl_rdata, 8'h5A);
        check("R4 status ibf only", lcl_status, 8'h02);
        check("R4 irq set", irq, 4'b0001);
        lcl_read(0, v);
        check("R4 local read value", v, 8'h5A);
        look(0);
        check("R4 ibf cleared", lcl_status, 8'h00);
        check("R4 irq cleared", irq, 4'b0000);
    endtask

    task automatic t_write_cmd();
        logic [DW-1:0] v;
        host_wr(4'b1101, 1'b1, 8'hD1);
        look(1);
        check("R3 cmd stored", lcl_rdata, 8'hD1);
        check("R3 cmd tag bit3", lcl_status, 8'h0A);
        host_rd(1, 1'b1, v);
        check("R2 host status read", v, 8'h0A);
        lcl_read(1, v);
        look(1);
        check("R4 clear keeps cmd tag", lcl_status, 8'h08);
    endtask

    task automatic t_obf();
        logic [DW-1:0] v;
        lcl_write(2, 8'h3C);
        host_rd(2, 1'b1, v);
        check("R5 obf set", v, 8'h01);
        host_rd(2, 1'b1, v);
        check("R5 status read keeps obf", v, 8'h01);
        host_rd(2, 1'b0, v);
        check("R2 host data read", v, 8'h3C);
        look(2);
        check("R5 obf cleared by data read", lcl_status, 8'h00);
    endtask

    task automatic t_indep();
        logic [DW-1:0] v;
        host_wr(4'b0111, 1'b0, 8'h77);
        check("R8 only ch3 irq", irq, 4'b1000);
        look(1);
        check("R8 ch1 untouched", lcl_status, 8'h08);
        lcl_read(3, v);
        host_wr(4'b1010, 1'b1, 8'h66);
        check("R8 lowest select wins", irq, 4'b0001);
        look(0);
        check("R8 ch0 data", lcl_rdata, 8'h66);
        look(2);
        check("R8 ch2 untouched", lcl_rdata, 8'h00);
        lcl_read(0, v);
        host_wr(4'b1111, 1'b0, 8'h55);
        check("R8 no select no irq", irq, 4'b0000);
        look(0);
        check("R8 no select keeps data", lcl_rdata, 8'h66);
    endtask

    task automatic t_both();
        lcl_write(0, 8'h11);
        @(negedge clk);
        hcs_n = 4'b1110; ha0 = 1'b0; hdin = 8'hEE; hwr_n = 1'b0; hrd_n = 1'b0;
        idle(4);
        hwr_n = 1'b1; hrd_n = 1'b1;
        idle(6);
        hcs_n = '1;
        look(0);
        check("R6 together: data kept", lcl_rdata, 8'h66);
        check("R6 together: flags kept", lcl_status, 8'h09);
        @(negedge clk);
        hcs_n = 4'b1110; hdin = 8'hEF; hwr_n = 1'b0; hrd_n = 1'b0;
        idle(3);
        hwr_n = 1'b1;
        idle(4);
        hrd_n = 1'b1;
        idle(6);
        hcs_n = '1;
        look(0);
        check("R6 staggered: data kept", lcl_rdata, 8'h66);
        check("R6 staggered: flags kept", lcl_status, 8'h09);
    endtask

    task automatic t_held();
        logic [DW-1:0] v;
        @(negedge clk);
        hcs_n = 4'b1011; ha0 = 1'b0; hdin = 8'h5C; hwr_n = 1'b0;
        idle(20);
        check("R7 no update while held", irq, 4'b0000);
        hwr_n = 1'b1;
        idle(6);
        hcs_n = '1;
        check("R7 one update on release", irq, 4'b0100);
        lcl_read(2, v);
        check("R7 data", v, 8'h5C);
        idle(10);
        check("R7 no repeat", irq, 4'b0000);
    endtask

    task automatic t_latency();
        logic [DW-1:0] v;
        @(negedge clk);
        hcs_n = 4'b0111; ha0 = 1'b0; hdin = 8'h44; hwr_n = 1'b0;
        idle(3);
        hwr_n = 1'b1;
        idle(1);
        check("R10 not after edge 1", irq[3], 1'b0);
        idle(1);
        check("R10 not after edge 2", irq[3], 1'b0);
        idle(1);
        check("R10 set after edge 3", irq[3], 1'b1);
        idle(4);
        hcs_n = '1;
        lcl_read(3, v);
    endtask

    task automatic t_collide();
        logic [DW-1:0] v;
        host_wr(4'b1110, 1'b0, 8'h10);
        @(negedge clk);
        hcs_n = 4'b1110; ha0 = 1'b0; hdin = 8'h20; hwr_n = 1'b0;
        idle(3);
        hwr_n = 1'b1;
        idle(2);
        lcl_ch = 2'd0; lcl_rd = 1'b1;
        #1 v = lcl_rdata;
        check("R9 old byte seen in collision cycle", v, 8'h10);
        @(negedge clk);
        lcl_rd = 1'b0;
        idle(4);
        hcs_n = '1;
        look(0);
        check("R9 ibf survives ack", lcl_status, 8'h03);
        check("R9 new inbound byte", lcl_rdata, 8'h20);
        lcl_read(0, v);

        lcl_write(1, 8'h21);
        @(negedge clk);
        hcs_n = 4'b1101; ha0 = 1'b0; hrd_n = 1'b0;
        idle(2);
        check("R2 outbound before collision", hdout, 8'h21);
        hrd_n = 1'b1;
        idle(2);
        lcl_ch = 2'd1; lcl_wdata = 8'h99; lcl_wr = 1'b1;
        @(negedge clk);
        lcl_wr = 1'b0;
        idle(4);
        hcs_n = '1;
        host_rd(1, 1'b1, v);
        check("R9 obf survives host read", v, 8'h09);
        host_rd(1, 1'b0, v);
        check("R9 new outbound byte", v, 8'h99);
        host_rd(1, 1'b1, v);
        check("R5 obf cleared after", v, 8'h08);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_write_data();
        t_write_cmd();
        t_obf();
        t_indep();
        t_both();
        t_held();
        t_latency();
        t_collide();
        idle(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule